// File: doc/BRIEF.md
# Signed Integer Width Converter

This block changes the size of a signed two's-complement integer between three widths: 8-bit byte, 16-bit word and 32-bit longword. A request carries the source value, a source size code and a destination size code. The result appears one clock later, together with sign, zero, overflow and carry flags, so a surrounding execution pipeline can take the converted value and its condition codes in the same cycle.

A wider destination is filled by sign extension. A narrower destination keeps only the low-order bits of the source. Overflow is raised when the bits thrown away do not all equal the sign bit of the value that remains. A request whose two size codes are equal, or that uses the unassigned size code, is rejected through a separate illegal-request output. No result is written for such a request.

Top module: `intConvert`

## Requirements
- R1: Size codes are 0 = byte (8 bits), 1 = word (16 bits) and 2 = longword (32 bits). A request with `inValid` high and two distinct assigned codes raises `outValid` for exactly the cycle after the clock edge that captured it.
- R2: When the destination is wider than the source, `outData` holds the source sign-extended to the destination width. Bits above the destination width are 0.
- R3: When the destination is narrower than the source, `outData` holds the low destination-width bits of the source. Bits above the destination width are 0.
- R4: On a narrowing conversion, `flagV` is 1 exactly when some discarded source bit differs from bit (destination width - 1) of the result.
- R5: A widening conversion always leaves `flagV` at 0.
- R6: `flagN` equals the top bit of the destination-width result, and `flagZ` is 1 exactly when the destination-width result is zero.
- R7: `flagC` is 0 after every conversion.
- R8: A request with equal size codes, or with code 3 on either side, raises `outIllegal` with `outValid` low in the following cycle. `outData` and all four flags keep their previous values.
- R9: In a cycle with `inValid` low, the next cycle shows `outValid` and `outIllegal` low, and `outData` and the flags are unchanged.
- R10: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Conversion request strobe |
| srcSize | input | 2 | Source size code |
| dstSize | input | 2 | Destination size code |
| srcData | input | 32 | Source value, right-justified |
| outValid | output | 1 | Registered result is from a legal request |
| outIllegal | output | 1 | Previous request had an illegal size pair |
| outData | output | 32 | Converted value, zero above destination width |
| flagN | output | 1 | Result negative |
| flagZ | output | 1 | Result zero |
| flagV | output | 1 | Integer overflow on narrowing |
| flagC | output | 1 | Carry, always cleared |

## Verification
Overflow detection and the zero flag can be raised by the same narrowing request. An example is a longword whose low byte is zero but whose upper bits are not, converted to a byte: both Z and V must be 1. Directed vectors such as 0x00000100 long-to-byte and 0x00010000 long-to-word provoke this case, and a stream of pseudo-random sizes and values adds more. The output flags are compared every clock against a behavioural model that computes the true signed value and tests it against the destination range. That model also checks that an illegal request arriving directly after a legal one leaves the earlier result untouched.

// File: rtl/intConvPkg.sv
package intConvPkg;
  localparam int DATA_W = 32;
  localparam int NUM_SIZES = 3;
  localparam int BASE_W = 8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  typedef struct packed {
    logic load;
    logic reject;
  } convCtrlT;
endpackage

// File: rtl/intConvCtrl.sv
module intConvCtrl
  import intConvPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] srcSize,
  input  logic [1:0] dstSize,
  output convCtrlT   strobes,
  output logic       outValid,
  output logic       outIllegal
);
  logic pairLegal;

  always_comb begin
    pairLegal = (srcSize != 2'd3) && (dstSize != 2'd3) && (srcSize != dstSize);
    strobes.load   = inValid && pairLegal;
    strobes.reject = inValid && !pairLegal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
    end else begin
      outValid   <= strobes.load;
      outIllegal <= strobes.reject;
    end
  end

  assert_illegal_pair_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && srcSize == dstSize) |=> (outIllegal && !outValid));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !outIllegal));
endmodule

// File: rtl/intConvData.sv
module intConvData
  import intConvPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  convCtrlT          strobes,
  input  logic [1:0]        srcSize,
  input  logic [1:0]        dstSize,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] outData,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);
  logic [DATA_W-1:0] extCand   [NUM_SIZES];
  logic [DATA_W-1:0] truncCand [NUM_SIZES];
  logic              signCand  [NUM_SIZES];
  logic              fitCand   [NUM_SIZES];
  logic [DATA_W-1:0] extValue;
  logic [DATA_W-1:0] nextData;
  logic              nextSign;
  logic              nextFit;

  // sign extension of the source, one candidate per size
  for (genvar g = 0; g < NUM_SIZES; g++) begin : genExt
    localparam int W = BASE_W << g;
    if (W < DATA_W) begin : genPad
      assign extCand[g] = {{(DATA_W-W){srcData[W-1]}}, srcData[W-1:0]};
    end else begin : genFull
      assign extCand[g] = srcData;
    end
  end

  always_comb begin
    case (srcSize)
      SZ_BYTE: extValue = extCand[0];
      SZ_WORD: extValue = extCand[1];
      default: extValue = extCand[2];
    endcase
  end

  // narrowing candidates: truncated value, its sign, and whether it fits
  for (genvar g = 0; g < NUM_SIZES; g++) begin : genNarrow
    localparam int W = BASE_W << g;
    logic [DATA_W-W:0] topBits;
    assign topBits = extValue[DATA_W-1:W-1];
    assign signCand[g] = extValue[W-1];
    assign fitCand[g]  = (&topBits) || !(|topBits);
    if (W < DATA_W) begin : genMask
      assign truncCand[g] = {{(DATA_W-W){1'b0}}, extValue[W-1:0]};
    end else begin : genKeep
      assign truncCand[g] = extValue;
    end
  end

  always_comb begin
    case (dstSize)
      SZ_BYTE: begin nextData = truncCand[0]; nextSign = signCand[0]; nextFit = fitCand[0]; end
      SZ_WORD: begin nextData = truncCand[1]; nextSign = signCand[1]; nextFit = fitCand[1]; end
      default: begin nextData = truncCand[2]; nextSign = signCand[2]; nextFit = fitCand[2]; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= '0;
      flagN   <= 1'b0;
      flagZ   <= 1'b0;
      flagV   <= 1'b0;
      flagC   <= 1'b0;
    end else if (strobes.load) begin
      outData <= nextData;
      flagN   <= nextSign;
      flagZ   <= (nextData == '0);
      flagV   <= !nextFit;
      flagC   <= 1'b0;
    end
  end

  assert_widen_no_v_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && srcSize < dstSize) |=> !flagV);

  assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && dstSize == SZ_BYTE) |=> (outData[DATA_W-1:BASE_W] == '0));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (flagZ == (outData == '0)));

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(outData) && $stable(flagV) && $stable(flagN)));
endmodule

// File: rtl/intConvert.sv
module intConvert
  import intConvPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  srcSize,
  input  logic [1:0]  dstSize,
  input  logic [31:0] srcData,
  output logic        outValid,
  output logic        outIllegal,
  output logic [31:0] outData,
  output logic        flagN,
  output logic        flagZ,
  output logic        flagV,
  output logic        flagC
);
  convCtrlT strobes;

  intConvCtrl ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .srcSize(srcSize), .dstSize(dstSize),
    .strobes(strobes), .outValid(outValid), .outIllegal(outIllegal)
  );

  intConvData data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .srcSize(srcSize), .dstSize(dstSize), .srcData(srcData),
    .outData(outData), .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );
endmodule

// File: tb/intConvert_test.sv
module intConvert_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  srcSize = 2'd0;
  logic [1:0]  dstSize = 2'd0;
  logic [31:0] srcData = 32'd0;
  logic        outValid, outIllegal, flagN, flagZ, flagV, flagC;
  logic [31:0] outData;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  bit          expValid = 0, expIllegal = 0, expN = 0, expZ = 0, expV = 0;
  logic [31:0] expData = 0;
  string       tagFlow = "R10", tagData = "R10", tagV = "R10";

  intConvert uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcSize(srcSize), .dstSize(dstSize),
    .srcData(srcData), .outValid(outValid), .outIllegal(outIllegal), .outData(outData),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkVal(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // true signed value tested against destination range
  task automatic refModel(input logic [1:0] s, input logic [1:0] d, input logic [31:0] x,
                          output logic [31:0] r, output bit n, output bit z, output bit v);
    int sw = 8 << s;
    int dw = 8 << d;
    longint val = longint'(x) & ((longint'(1) << sw) - 1);
    longint lo = -(longint'(1) << (dw - 1));
    longint hi = (longint'(1) << (dw - 1)) - 1;
    longint res;
    if (((val >> (sw - 1)) & 1) != 0) val = val - (longint'(1) << sw);
    v = (val < lo) || (val > hi);
    res = val & ((longint'(1) << dw) - 1);
    r = res[31:0];
    n = res[dw-1];
    z = (res == 0);
  endtask

  task automatic compareAll();
    checkVal(tagFlow, "outValid", {31'd0, outValid}, {31'd0, expValid});
    checkVal(tagFlow, "outIllegal", {31'd0, outIllegal}, {31'd0, expIllegal});
    checkVal(tagData, "outData", outData, expData);
    checkVal(tagV, "flagV", {31'd0, flagV}, {31'd0, expV});
    checkVal("R6", "flagN", {31'd0, flagN}, {31'd0, expN});
    checkVal("R6", "flagZ", {31'd0, flagZ}, {31'd0, expZ});
    checkVal("R7", "flagC", {31'd0, flagC}, 32'd0);
  endtask

  task automatic step(input bit v, input logic [1:0] s, input logic [1:0] d, input logic [31:0] x);
    bit legal;
    logic [31:0] r;
    bit n, z, ov;
    @(negedge clk);
    compareAll();
    inValid = v; srcSize = s; dstSize = d; srcData = x;
    legal = v && s != 2'd3 && d != 2'd3 && s != d;
    expValid = legal;
    expIllegal = v && !legal;
    if (legal) begin
      refModel(s, d, x, r, n, z, ov);
      expData = r; expN = n; expZ = z; expV = ov;
      tagFlow = "R1";
      tagData = (s < d) ? "R2" : "R3";
      tagV = (s < d) ? "R5" : "R4";
    end else begin
      tagFlow = v ? "R8" : "R9";
      tagData = tagFlow;
      tagV = tagFlow;
    end
  endtask

  initial begin
    int seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    compareAll();                       // R10 reset values
    rstN = 1'b1;
    step(1, 2'd0, 2'd1, 32'h0000_0080); // R2 byte->word negative
    step(1, 2'd0, 2'd2, 32'hFFFF_FF7F); // R2 byte->long positive
    step(1, 2'd1, 2'd0, 32'h0000_0080); // R4 word->byte overflow
    step(1, 2'd1, 2'd0, 32'h0000_FF80); // R3 word->byte fits
    step(1, 2'd2, 2'd0, 32'h0000_0100); // R4 + R6 V and Z together
    step(1, 2'd2, 2'd1, 32'hFFFF_8000); // R3 long->word fits negative
    step(1, 2'd2, 2'd1, 32'h0000_8000); // R4 long->word overflow
    step(1, 2'd2, 2'd1, 32'h0001_0000); // R4 + R6 V and Z together
    step(1, 2'd1, 2'd1, 32'hDEAD_BEEF); // R8 equal sizes
    step(1, 2'd3, 2'd0, 32'h0000_0001); // R8 reserved code
    step(0, 2'd2, 2'd0, 32'h0000_0055); // R9 idle
    step(1, 2'd1, 2'd2, 32'h0000_8001); // R2 word->long
    step(1, 2'd0, 2'd3, 32'h0000_0001); // R8 right after legal
    for (int i = 0; i < 300; i++) begin
      seed = seed * 1103515245 + 12345;
      step(seed[30] | seed[29], seed[17:16], seed[21:20], {seed[7:0], seed[31:8]} ^ seed);
    end
    step(0, 2'd0, 2'd0, 32'd0);
    @(negedge clk);
    compareAll();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule